// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block is the host-facing register file that sits between a simple strobed word bus and an external hash compression engine. The host loads the sixteen 32-bit words of a 512-bit message block and writes a command word. The block turns each command write into a single one-clock start pulse toward the engine. One pulse kind starts a fresh hash. The other chains a further block onto the digest the engine already holds. The host then polls a status word until it reads non-zero and fetches the 256-bit digest as eight words. Three constant identification words let software recognise the block.

Every transfer takes exactly one clock with the strobe high. The write-enable input picks the direction. The bus applies no back-pressure: the block answers every strobe in its own cycle with either an acknowledge or an error. Read data is produced combinationally within that cycle. The engine connections are plain level and pulse signals, with no handshake. The hash arithmetic lives outside this block.

Top module: `hash_regfront`

## Requirements
- R1: In every cycle with `bus_stb` high exactly one of `bus_ack` and `bus_err` is high in that same cycle. With `bus_stb` low both are low.
- R2: Reads of word addresses 0x00, 0x01 and 0x02 return the identification constants. With the default parameters these are 0x73686132, 0x2d323536 and 0x312e3030, each holding four ASCII characters with the first character in bits 31:24.
- R3: Word addresses 0x10 to 0x1F are read/write message words. The word at 0x10 drives `eng_block[511:480]`, and each higher address drives the next lower 32 bits, down to 0x1F driving `eng_block[31:0]`. Reading a message word returns the value last written to it.
- R4: The command word is at 0x08. A write with bit 0 set gives exactly one clock of `eng_init` in the cycle after the write. A write with bit 1 set and bit 0 clear gives exactly one clock of `eng_next`. When both bits are set, only `eng_init` is produced. A write of zero gives no pulse. Reading 0x08 returns zero.
- R5: The status word at 0x09 carries `eng_ready` in bit 0 and `eng_digest_valid` in bit 1, with all other bits zero. It reads as zero in any cycle where `eng_init` or `eng_next` is high.
- R6: Word addresses 0x20 to 0x27 return the digest. 0x20 returns `eng_digest[255:224]`, and each higher address returns the next lower 32 bits, down to 0x27 returning `eng_digest[31:0]`.
- R7: A write to a read-only address (0x00 to 0x02, 0x09, 0x20 to 0x27) or to any unmapped address raises `bus_err` instead of `bus_ack`. It changes no message word and produces no pulse.
- R8: A read from an unmapped address is acknowledged and returns zero.
- R9: Reset (active-low `rst_n`, asynchronous) clears all message words to zero and holds `eng_init` and `eng_next` low.
- R10: `bus_rdata` carries the addressed word in the same cycle as a read strobe and is zero in any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stb | input | 1 | Transfer strobe, one cycle per transfer |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| bus_ack | output | 1 | Transfer accepted |
| bus_err | output | 1 | Transfer refused (write to read-only or unmapped word) |
| eng_block | output | 512 | Message block toward the engine |
| eng_init | output | 1 | One-cycle pulse: start a new hash |
| eng_next | output | 1 | One-cycle pulse: hash a further chained block |
| eng_ready | input | 1 | Engine idle and able to accept a command |
| eng_digest_valid | input | 1 | Engine digest holds a finished result |
| eng_digest | input | 256 | Digest from the engine |

## Verification
Some properties are checked on every cycle. These are the strobe response (one of acknowledge or error, never both), the exact match between command writes and the pulses in the following cycle, and the exclusion of simultaneous init and next. They also cover the stable block after a refused write, the zero status while a pulse is out, the landing of the first message word in the top bits, and the reset state. Other behaviour only the bench scenarios can show: the full ordering of message and digest words, one pulse per command when the host writes zero back, and the busy-to-ready status sequence seen through polling against a stub engine. They also show the identification constants and that refused writes leave read-only words and pulses untouched.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

  localparam int ADDR_W   = 8;
  localparam int ID_WORDS = 3;

  localparam logic [ADDR_W-1:0] CMD_ADDR  = 8'h08;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h09;
  localparam logic [ADDR_W-1:0] MSG_BASE  = 8'h10;
  localparam logic [ADDR_W-1:0] DIG_BASE  = 8'h20;

  localparam int CMD_INIT_BIT   = 0;
  localparam int CMD_NEXT_BIT   = 1;
  localparam int STAT_READY_BIT = 0;
  localparam int STAT_VALID_BIT = 1;

  typedef enum logic [2:0] {
    RG_ID,
    RG_CMD,
    RG_STAT,
    RG_MSG,
    RG_DIG,
    RG_NONE
  } rg_kind_e;

endpackage

// File: rtl/hrf_decode.sv
module hrf_decode
  import hrf_pkg::*;
#(
  parameter int MSG_WORDS = 16,
  parameter int DIG_WORDS = 8,
  parameter int IDX_W     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output rg_kind_e          kind,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W-1:0] ID_N  = ADDR_W'(ID_WORDS);
  localparam logic [ADDR_W-1:0] MSG_N = ADDR_W'(MSG_WORDS);
  localparam logic [ADDR_W-1:0] DIG_N = ADDR_W'(DIG_WORDS);

  logic [ADDR_W-1:0] msg_off;
  logic [ADDR_W-1:0] dig_off;

  // Offsets wrap for addresses below a base, so one compare covers both ends.
  assign msg_off = addr - MSG_BASE;
  assign dig_off = addr - DIG_BASE;

  always_comb begin
    kind = RG_NONE;
    idx  = '0;
    if (addr < ID_N) begin
      kind = RG_ID;
      idx  = IDX_W'(addr);
    end else if (addr == CMD_ADDR) begin
      kind = RG_CMD;
    end else if (addr == STAT_ADDR) begin
      kind = RG_STAT;
    end else if (msg_off < MSG_N) begin
      kind = RG_MSG;
      idx  = IDX_W'(msg_off);
    end else if (dig_off < DIG_N) begin
      kind = RG_DIG;
      idx  = IDX_W'(dig_off);
    end
  end

endmodule

// File: rtl/hrf_msg_store.sv
module hrf_msg_store #(
  parameter int WORD_W    = 32,
  parameter int MSG_WORDS = 16,
  parameter int IDX_W     = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WORD_W-1:0]           wr_data,
  output logic [WORD_W*MSG_WORDS-1:0] block
);

  for (genvar g = 0; g < MSG_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        word_q <= wr_data;
      end
    end

    // Lowest address feeds the most significant slice.
    assign block[(MSG_WORDS-1-g)*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/hrf_cmd_pulse.sv
module hrf_cmd_pulse
  import hrf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] cmd,
  output logic       init_p,
  output logic       next_p
);

  // Each pulse is recomputed every clock, so it lasts one cycle per write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_p <= 1'b0;
      next_p <= 1'b0;
    end else begin
      init_p <= wr_en & cmd[CMD_INIT_BIT];
      next_p <= wr_en & cmd[CMD_NEXT_BIT] & ~cmd[CMD_INIT_BIT];
    end
  end

endmodule

// File: rtl/hrf_read_mux.sv
module hrf_read_mux
  import hrf_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MSG_WORDS = 16,
  parameter int DIG_WORDS = 8,
  parameter int IDX_W     = 4
) (
  input  logic                        rd_en,
  input  rg_kind_e                    kind,
  input  logic [IDX_W-1:0]            idx,
  input  logic [WORD_W*ID_WORDS-1:0]  id_words,
  input  logic [WORD_W*MSG_WORDS-1:0] block,
  input  logic [WORD_W*DIG_WORDS-1:0] digest,
  input  logic                        ready,
  input  logic                        valid,
  input  logic                        busy,
  output logic [WORD_W-1:0]           rdata
);

  logic [WORD_W-1:0] word;

  always_comb begin
    word = '0;
    unique case (kind)
      RG_ID: begin
        for (int i = 0; i < ID_WORDS; i++) begin
          if (idx == IDX_W'(i)) word = id_words[(ID_WORDS-1-i)*WORD_W +: WORD_W];
        end
      end
      RG_MSG: begin
        for (int i = 0; i < MSG_WORDS; i++) begin
          if (idx == IDX_W'(i)) word = block[(MSG_WORDS-1-i)*WORD_W +: WORD_W];
        end
      end
      RG_DIG: begin
        for (int i = 0; i < DIG_WORDS; i++) begin
          if (idx == IDX_W'(i)) word = digest[(DIG_WORDS-1-i)*WORD_W +: WORD_W];
        end
      end
      RG_STAT: begin
        if (!busy) begin
          word[STAT_READY_BIT] = ready;
          word[STAT_VALID_BIT] = valid;
        end
      end
      default: word = '0;
    endcase
  end

  assign rdata = rd_en ? word : '0;

endmodule

// File: rtl/hash_regfront.sv
module hash_regfront
  import hrf_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MSG_WORDS = 16,
  parameter int DIG_WORDS = 8,
  parameter logic [WORD_W*ID_WORDS-1:0] ID_VALUE = {32'h73686132, 32'h2d323536, 32'h312e3030}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_stb,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic [WORD_W-1:0]           bus_rdata,
  output logic                        bus_ack,
  output logic                        bus_err,
  output logic [WORD_W*MSG_WORDS-1:0] eng_block,
  output logic                        eng_init,
  output logic                        eng_next,
  input  logic                        eng_ready,
  input  logic                        eng_digest_valid,
  input  logic [WORD_W*DIG_WORDS-1:0] eng_digest
);

  localparam int MAX_WORDS = (MSG_WORDS > DIG_WORDS) ? MSG_WORDS : DIG_WORDS;
  localparam int IDX_W     = (MAX_WORDS > ID_WORDS) ? $clog2(MAX_WORDS) : $clog2(ID_WORDS);

  rg_kind_e         kind;
  logic [IDX_W-1:0] idx;
  logic             writable;
  logic             wr_ok;

  hrf_decode #(
    .MSG_WORDS(MSG_WORDS),
    .DIG_WORDS(DIG_WORDS),
    .IDX_W    (IDX_W)
  ) u_decode (
    .addr(bus_addr),
    .kind(kind),
    .idx (idx)
  );

  assign writable = (kind == RG_MSG) || (kind == RG_CMD);
  assign wr_ok    = bus_stb & bus_we & writable;
  assign bus_err  = bus_stb & bus_we & ~writable;
  assign bus_ack  = bus_stb & ~bus_err;

  hrf_msg_store #(
    .WORD_W   (WORD_W),
    .MSG_WORDS(MSG_WORDS),
    .IDX_W    (IDX_W)
  ) u_msg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_ok && (kind == RG_MSG)),
    .wr_idx (idx),
    .wr_data(bus_wdata),
    .block  (eng_block)
  );

  hrf_cmd_pulse u_cmd (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_ok && (kind == RG_CMD)),
    .cmd   (bus_wdata[1:0]),
    .init_p(eng_init),
    .next_p(eng_next)
  );

  hrf_read_mux #(
    .WORD_W   (WORD_W),
    .MSG_WORDS(MSG_WORDS),
    .DIG_WORDS(DIG_WORDS),
    .IDX_W    (IDX_W)
  ) u_rmux (
    .rd_en   (bus_stb & ~bus_we),
    .kind    (kind),
    .idx     (idx),
    .id_words(ID_VALUE),
    .block   (eng_block),
    .digest  (eng_digest),
    .ready   (eng_ready),
    .valid   (eng_digest_valid),
    .busy    (eng_init | eng_next),
    .rdata   (bus_rdata)
  );

endmodule

// File: rtl/hrf_checker.sv
module hrf_checker
  import hrf_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MSG_WORDS = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_stb,
  input logic                        bus_we,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [WORD_W-1:0]           bus_wdata,
  input logic [WORD_W-1:0]           bus_rdata,
  input logic                        bus_ack,
  input logic                        bus_err,
  input logic [WORD_W*MSG_WORDS-1:0] eng_block,
  input logic                        eng_init,
  input logic                        eng_next
);

  localparam int TOP = WORD_W*MSG_WORDS - WORD_W;

  logic cmd_wr;
  logic init_req;
  logic next_req;
  logic past_ok;

  assign cmd_wr   = bus_stb && bus_we && (bus_addr == CMD_ADDR);
  assign init_req = cmd_wr && bus_wdata[CMD_INIT_BIT];
  assign next_req = cmd_wr && bus_wdata[CMD_NEXT_BIT] && !bus_wdata[CMD_INIT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  strobe_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb |-> (bus_ack != bus_err));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_stb |-> (!bus_ack && !bus_err));

  // R4
  init_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (eng_init == $past(init_req)));

  // R4
  next_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (eng_next == $past(next_req)));

  // R4
  single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_init && eng_next));

  // R7
  err_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_we);

  // R7
  err_keeps_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> $stable(eng_block));

  // R5
  status_busy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && !bus_we && (bus_addr == STAT_ADDR) && (eng_init || eng_next)) |-> (bus_rdata == '0));

  // R3
  first_word_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && bus_we && (bus_addr == MSG_BASE)) |=> (eng_block[TOP +: WORD_W] == $past(bus_wdata)));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (eng_block == '0 && !eng_init && !eng_next));

endmodule

bind hash_regfront hrf_checker #(
  .WORD_W   (WORD_W),
  .MSG_WORDS(MSG_WORDS)
) u_chk (.*);

// File: tb/hash_regfront_tb.sv
module hash_regfront_tb;
  import hrf_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         bus_stb = 1'b0;
  logic         bus_we = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_ack;
  logic         bus_err;
  logic [511:0] eng_block;
  logic         eng_init;
  logic         eng_next;
  logic         st_ready;
  logic         st_valid;
  logic [255:0] st_dig;
  int           st_cnt;

  int checks = 0;
  int errors = 0;
  int init_seen = 0;
  int next_seen = 0;

  localparam logic [31:0] ID0 = 32'h73686132;
  localparam logic [31:0] ID1 = 32'h2d323536;
  localparam logic [31:0] ID2 = 32'h312e3030;

  hash_regfront u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_stb(bus_stb), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err),
    .eng_block(eng_block), .eng_init(eng_init), .eng_next(eng_next),
    .eng_ready(st_ready), .eng_digest_valid(st_valid), .eng_digest(st_dig)
  );

  function automatic logic [255:0] fold(input logic [511:0] b);
    return b[511:256] ^ ~b[255:0];
  endfunction

  // Stub engine: busy for a few cycles after a pulse, then ready and valid.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ready <= 1'b1; st_valid <= 1'b0; st_dig <= '0; st_cnt <= 0;
    end else if (eng_init) begin
      st_ready <= 1'b0; st_valid <= 1'b0; st_cnt <= 6;
      st_dig <= fold(eng_block);
    end else if (eng_next) begin
      st_ready <= 1'b0; st_valid <= 1'b0; st_cnt <= 6;
      st_dig <= fold(eng_block) ^ {st_dig[254:0], st_dig[255]};
    end else if (st_cnt != 0) begin
      st_cnt <= st_cnt - 1;
      if (st_cnt == 1) begin st_ready <= 1'b1; st_valid <= 1'b1; end
    end
  end

  // Reference model state
  logic [31:0] m_msg [16];
  logic        m_init;
  logic        m_next;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_msg[i] <= '0;
      m_init <= 1'b0; m_next <= 1'b0;
    end else begin
      m_init <= bus_stb && bus_we && bus_addr == 8'h08 && bus_wdata[0];
      m_next <= bus_stb && bus_we && bus_addr == 8'h08 && bus_wdata[1] && !bus_wdata[0];
      if (bus_stb && bus_we && bus_addr >= 8'h10 && bus_addr <= 8'h1f)
        m_msg[bus_addr - 8'h10] <= bus_wdata;
    end
  end

  function automatic logic [511:0] m_block();
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[(15-i)*32 +: 32] = m_msg[i];
    return b;
  endfunction

  function automatic logic [31:0] exp_word(input logic [7:0] a);
    if (a == 8'h00) return ID0;
    if (a == 8'h01) return ID1;
    if (a == 8'h02) return ID2;
    if (a == 8'h09) return (m_init || m_next) ? 32'h0 : {30'b0, st_valid, st_ready};
    if (a >= 8'h10 && a <= 8'h1f) return m_msg[a - 8'h10];
    if (a >= 8'h20 && a <= 8'h27) return st_dig[(7 - int'(a - 8'h20))*32 +: 32];
    return 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  logic        e_err;
  logic        e_ack;
  logic [31:0] e_rd;
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      e_err = bus_stb && bus_we && !(bus_addr == 8'h08 || (bus_addr >= 8'h10 && bus_addr <= 8'h1f));
      e_ack = bus_stb && !e_err;
      e_rd  = (bus_stb && !bus_we) ? exp_word(bus_addr) : 32'h0;
      chk(bus_ack == e_ack && bus_err == e_err, "R1 ack/err", {bus_ack, bus_err}, {e_ack, e_err});
      chk(bus_rdata == e_rd, "R10 rdata", bus_rdata, e_rd);
      chk(eng_init == m_init && eng_next == m_next, "R4 pulses", {eng_init, eng_next}, {m_init, m_next});
      chk(eng_block == m_block(), "R3 block", eng_block, m_block());
      if (eng_init) init_seen++;
      if (eng_next) next_seen++;
    end
  end

  logic [31:0] rd;
  logic        rack;
  logic        rerr;

  task automatic xfer(input logic we, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    #5;
    rd = bus_rdata; rack = bus_ack; rerr = bus_err;
    @(negedge clk);
    bus_stb = 1'b0; bus_we = 1'b0;
  endtask

  // Command write immediately followed by a status read in the pulse cycle.
  task automatic cmd_then_status(input logic [31:0] c);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b1; bus_addr = 8'h08; bus_wdata = c;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h09;
    #5;
    rd = bus_rdata;
    @(negedge clk);
    bus_stb = 1'b0;
  endtask

  task automatic write_block(input logic [511:0] b);
    for (int i = 0; i < 16; i++) xfer(1'b1, 8'h10 + 8'(i), b[(15-i)*32 +: 32]);
  endtask

  task automatic read_digest(output logic [255:0] d);
    for (int i = 0; i < 8; i++) begin
      xfer(1'b0, 8'h20 + 8'(i), 32'h0);
      d[(7-i)*32 +: 32] = rd;
    end
  endtask

  task automatic wait_done(output int polls);
    polls = 0;
    rd = 32'h0;
    while (rd == 32'h0) begin
      xfer(1'b0, 8'h09, 32'h0);
      polls++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [511:0] b1;
    logic [511:0] b2;
    logic [255:0] dg;
    logic [255:0] exp_dg;
    int polls;
    int i0;
    int n0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(eng_block == '0 && !eng_init && !eng_next, "R9 reset state", {eng_block, eng_init, eng_next}, '0);

    // R2 identification words
    xfer(1'b0, 8'h00, 0); chk(rd == ID0 && rack, "R2 id0", rd, ID0);
    xfer(1'b0, 8'h01, 0); chk(rd == ID1 && rack, "R2 id1", rd, ID1);
    xfer(1'b0, 8'h02, 0); chk(rd == ID2 && rack, "R2 id2", rd, ID2);

    // R8 unmapped reads
    xfer(1'b0, 8'h05, 0); chk(rd == 0 && rack && !rerr, "R8 read 0x05", rd, 0);
    xfer(1'b0, 8'h28, 0); chk(rd == 0 && rack && !rerr, "R8 read 0x28", rd, 0);
    xfer(1'b0, 8'hff, 0); chk(rd == 0 && rack && !rerr, "R8 read 0xff", rd, 0);

    // R3 message ordering
    for (int i = 0; i < 16; i++) b1[(15-i)*32 +: 32] = 32'h1000_0000 * (i + 1) + 32'h0000_1234 * i;
    write_block(b1);
    chk(eng_block == b1, "R3 block order", eng_block, b1);
    xfer(1'b0, 8'h13, 0); chk(rd == b1[415:384], "R3 readback 0x13", rd, b1[415:384]);
    xfer(1'b0, 8'h08, 0); chk(rd == 0 && rack, "R4 cmd reads zero", rd, 0);

    // R4 / R5 init command
    i0 = init_seen; n0 = next_seen;
    cmd_then_status(32'h1);
    chk(rd == 0, "R5 status masked in pulse cycle", rd, 0);
    xfer(1'b1, 8'h08, 32'h0);
    xfer(1'b0, 8'h09, 0);
    chk(rd == 0, "R5 status zero while busy", rd, 0);
    wait_done(polls);
    chk(rd == 32'h3, "R5 status ready and valid", rd, 32'h3);
    chk(init_seen - i0 == 1 && next_seen == n0, "R4 one init pulse", init_seen - i0, 1);
    read_digest(dg);
    exp_dg = fold(b1);
    chk(dg == exp_dg, "R6 digest order", dg, exp_dg);

    // R4 chained command
    b2 = ~b1 ^ {16{32'h0f0f_5a5a}};
    write_block(b2);
    i0 = init_seen; n0 = next_seen;
    xfer(1'b1, 8'h08, 32'h2);
    xfer(1'b1, 8'h08, 32'h0);
    wait_done(polls);
    chk(next_seen - n0 == 1 && init_seen == i0, "R4 one next pulse", next_seen - n0, 1);
    read_digest(dg);
    exp_dg = fold(b2) ^ {exp_dg[254:0], exp_dg[255]};
    chk(dg == exp_dg, "R6 chained digest", dg, exp_dg);

    // R4 both bits set gives init only
    i0 = init_seen; n0 = next_seen;
    xfer(1'b1, 8'h08, 32'h3);
    xfer(1'b1, 8'h08, 32'h0);
    wait_done(polls);
    chk(init_seen - i0 == 1 && next_seen == n0, "R4 both bits", {init_seen - i0, next_seen - n0}, {32'd1, 32'd0});

    // R7 refused writes
    i0 = init_seen; n0 = next_seen;
    xfer(1'b1, 8'h00, 32'hdead_beef); chk(rerr && !rack, "R7 write id", {rack, rerr}, 2'b01);
    xfer(1'b1, 8'h09, 32'h1);         chk(rerr && !rack, "R7 write status", {rack, rerr}, 2'b01);
    xfer(1'b1, 8'h20, 32'h1);         chk(rerr && !rack, "R7 write digest", {rack, rerr}, 2'b01);
    xfer(1'b1, 8'h40, 32'h1);         chk(rerr && !rack, "R7 write unmapped", {rack, rerr}, 2'b01);
    xfer(1'b0, 8'h00, 0); chk(rd == ID0, "R7 id unchanged", rd, ID0);
    chk(eng_block == b2, "R7 block unchanged", eng_block, b2);
    chk(init_seen == i0 && next_seen == n0, "R7 no pulse", {init_seen, next_seen}, {i0, n0});

    // R9 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(eng_block == '0 && !eng_init && !eng_next, "R9 reset clears", eng_block, '0);
    rst_n = 1'b1;
    xfer(1'b0, 8'h1f, 0); chk(rd == 0, "R9 word reads zero", rd, 0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule